// File: doc/BRIEF.md
# EEPROM Write-Completion Poller

This block is the master side of a two-wire serial bus, used after a write to a serial EEPROM. While the memory is busy with its internal programming cycle, it does not acknowledge its own address. The poller finds the end of that cycle by sending probes. Each probe is a START condition followed by the slave address in write mode. A probe that is not acknowledged is closed with a STOP, and another probe follows.

Once a probe is acknowledged, the command decides what happens next. If the next operation is a write, the block clocks out the byte address, takes the slave's acknowledge slot, and leaves the bus held with SCL low so that a data phase can follow. If the next operation is not a write, it closes the bus with a STOP. If the number of probes reaches a parameter limit without an acknowledge, it gives up with a timeout. In every case it ends with a one-cycle done pulse, a result code and the number of probes it sent.

SCL comes from a clock divider. Each bit lasts four quarter periods of `QDIV` system clocks. SDA is open-drain: the block only pulls it low or releases it, and it reads the wire back on `sda_i`.

Top module: `ackpoll_seq`

## Requirements
- R1: After reset, SCL is high, SDA is released (`sda_oe` = 0), `cmd_ready` is 1 and `done` is 0.
- R2: Each probe is a START (SDA falls while SCL is high) followed by eight bits, MSB first, sent on SCL rising edges: the 7-bit device address, then a 0 for write.
- R3: A probe with no acknowledge (SDA high in the ninth clock) is ended with a STOP and followed by a new probe. `attempts` reports the number of probes sent and never exceeds `MAX_TRIES`.
- R4: When a probe is acknowledged and `cmd_next_write` = 0, the block issues one STOP and ends with result 0 (ready). After this, SCL is high and SDA is released.
- R5: When a probe is acknowledged and `cmd_next_write` = 1, the block sends the byte address MSB first and clocks a ninth acknowledge bit. It issues no STOP after the acknowledged probe and ends with result 1 (write continued), with SCL held low.
- R6: If `MAX_TRIES` probes are all unacknowledged, the last one is closed with a STOP. The block then ends with result 2 (timeout) and `attempts` = `MAX_TRIES`.
- R7: While SCL is high, SDA changes only as part of a START or STOP. During every ninth (acknowledge) bit the master releases SDA.
- R8: `done` is high for exactly one cycle per command. A `cmd_valid` pulse while a command is running is ignored: the address sent and the result produced are those of the command that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Starts a polling command; taken only while `cmd_ready` is 1 |
| cmd_next_write | input | 1 | 1: the next operation is a write, so continue with the byte address |
| cmd_dev_addr | input | DEV_W | Slave device address |
| cmd_byte_addr | input | BA_W | Byte address sent when continuing into a write |
| cmd_ready | output | 1 | The block is idle and accepts a command |
| done | output | 1 | One-cycle pulse when a command ends |
| result | output | 2 | 0 = ready, 1 = write continued, 2 = timeout; valid from `done` until the next command |
| attempts | output | $clog2(MAX_TRIES+1) | Number of probes sent for the last command |
| scl_o | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| sda_i | input | 1 | SDA line as read back from the wire |

## Verification
The embedded assertions check on every cycle these properties:
- SDA never changes while SCL is high outside a START or STOP.
- The master releases SDA throughout each acknowledge bit.
- `done` never lasts two cycles.
- A timeout always reports exactly `MAX_TRIES` probes.
- Ready leaves the bus idle-high, and write-continued leaves SCL low.

Other behaviour can only be shown by the bench's scenarios, which use a bus-level slave model that stays busy for a chosen number of probes. These scenarios show:
- the bit order and content of the address and byte-address frames;
- the relation between busy duration, probe count, STOP count and result code;
- a command that falls through to timeout because the device address does not match;
- a stray command that arrives mid-run and is ignored.

// File: rtl/ackpoll_pkg.sv
// Shared encodings for the acknowledge-polling sequencer.
package ackpoll_pkg;
    // Bus symbol handed from the byte sequencer to the bit engine.
    typedef enum logic [1:0] {
        SYM_START = 2'd0,
        SYM_STOP  = 2'd1,
        SYM_BIT   = 2'd2
    } sym_e;

    // Result codes reported with done.
    localparam logic [1:0] RES_READY   = 2'd0;
    localparam logic [1:0] RES_WRCONT  = 2'd1;
    localparam logic [1:0] RES_TIMEOUT = 2'd2;
endpackage

// File: rtl/ackpoll_tick.sv
// Quarter-bit tick generator.
// Emits one tick every QDIV clocks while en is high. The count restarts
// whenever en is low, so the first tick of a symbol always comes QDIV
// cycles after the symbol starts.
// Assumes QDIV >= 1.
module ackpoll_tick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

    generate
        if (QDIV == 1) begin : g_nodiv
            assign tick = en;
        end else begin : g_div
            logic [CW-1:0] cnt;

            // Count clocks inside one quarter period.
            always_ff @(posedge clk) begin
                if (!rst_n || !en) begin
                    cnt <= '0;
                end else if (cnt == CW'(QDIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = en && (cnt == CW'(QDIV - 1));
        end
    endgenerate
endmodule

// File: rtl/ackpoll_phy.sv
// Bit engine for the two-wire bus.
// Runs one symbol (START, STOP or one data bit) over four quarter phases and
// pulses done at the end. For data bits it samples SDA at the end of the
// first SCL-high quarter. Outputs are registered.
// Assumes a START follows either an idle bus or a symbol that left SCL low,
// and that sda_i is already synchronous to clk.
module ackpoll_phy
    import ackpoll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic go,
    input  sym_e kind,
    input  logic tx_bit,
    input  logic sda_i,
    output logic active,
    output logic done,
    output logic rx_bit,
    output logic scl_o,
    output logic sda_oe
);
    logic [1:0] q;
    sym_e       kind_q;
    logic       bit_q;

    // Pin levels {scl, pull_low} for one quarter of one symbol.
    function automatic logic [1:0] drive(input sym_e k, input logic [1:0] ph,
                                         input logic b, input logic scl_prev);
        logic [1:0] r;
        case (k)
            SYM_START: case (ph)
                2'd0:    r = {scl_prev, 1'b0};
                2'd1:    r = {1'b1, 1'b0};
                2'd2:    r = {1'b1, 1'b1};
                default: r = {1'b0, 1'b1};
            endcase
            SYM_STOP: case (ph)
                2'd0:    r = {1'b0, 1'b1};
                2'd1:    r = {1'b1, 1'b1};
                default: r = {1'b1, 1'b0};
            endcase
            default: case (ph)
                2'd0, 2'd3: r = {1'b0, ~b};
                default:    r = {1'b1, ~b};
            endcase
        endcase
        return r;
    endfunction

    // Symbol sequencing, pin drive and acknowledge sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            done   <= 1'b0;
            q      <= 2'd0;
            kind_q <= SYM_STOP;
            bit_q  <= 1'b1;
            rx_bit <= 1'b1;
            scl_o  <= 1'b1;
            sda_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active && go) begin
                active <= 1'b1;
                q      <= 2'd0;
                kind_q <= kind;
                bit_q  <= tx_bit;
                {scl_o, sda_oe} <= drive(kind, 2'd0, tx_bit, scl_o);
            end else if (active && tick) begin
                if (q == 2'd1 && kind_q == SYM_BIT) begin
                    rx_bit <= sda_i;
                end
                if (q == 2'd3) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    q <= q + 2'd1;
                    {scl_o, sda_oe} <= drive(kind_q, q + 2'd1, bit_q, scl_o);
                end
            end
        end
    end

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_o) && scl_o && (sda_oe != $past(sda_oe))) |-> (kind_q != SYM_BIT)); // R7
endmodule

// File: rtl/ackpoll_ctrl.sv
// Byte-level sequencer for acknowledge polling.
// Accepts one command at a time. It loops over the sequence START, address
// frame (device address + write bit), acknowledge bit, STOP until the slave
// acknowledges or MAX_TRIES probes have been sent. On acknowledge it either
// sends STOP (ready) or the byte address plus its acknowledge bit (write
// continued).
// Assumes the bit engine takes one go pulse per symbol and answers with sym_done.
module ackpoll_ctrl
    import ackpoll_pkg::*;
#(
    parameter int DEV_W     = 7,
    parameter int BA_W      = 8,
    parameter int MAX_TRIES = 8,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_next_write,
    input  logic [DEV_W-1:0] cmd_dev,
    input  logic [BA_W-1:0]  cmd_baddr,
    output logic             cmd_ready,
    output logic             sym_go,
    output sym_e             sym_kind,
    output logic             sym_bit,
    input  logic             sym_done,
    input  logic             rx_bit,
    output logic             in_ack,
    output logic             done,
    output logic [1:0]       result,
    output logic [CNT_W-1:0] attempts
);
    localparam int FR_W  = DEV_W + 1;
    localparam int SH_W  = (FR_W > BA_W) ? FR_W : BA_W;
    localparam int IDX_W = $clog2(SH_W + 1);

    typedef enum logic [2:0] {
        C_IDLE, C_START, C_ADDR, C_ACK, C_STOP, C_BADDR, C_BACK
    } cstate_e;

    cstate_e          st;
    logic [SH_W-1:0]  sh;
    logic [IDX_W-1:0] idx;
    logic             issued;
    logic             retry_q;
    logic [1:0]       pend_q;
    logic             nw_q;
    logic [DEV_W-1:0] dev_q;
    logic [BA_W-1:0]  baddr_q;

    // Symbol selection for the current state.
    always_comb begin
        sym_bit = 1'b1;
        case (st)
            C_START: sym_kind = SYM_START;
            C_STOP:  sym_kind = SYM_STOP;
            C_ADDR, C_BADDR: begin
                sym_kind = SYM_BIT;
                sym_bit  = sh[SH_W-1];
            end
            default: sym_kind = SYM_BIT;
        endcase
    end

    assign cmd_ready = (st == C_IDLE);
    assign in_ack    = (st == C_ACK) || (st == C_BACK);

    // Command capture, symbol issue and state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= C_IDLE;
            sh       <= '0;
            idx      <= '0;
            issued   <= 1'b0;
            retry_q  <= 1'b0;
            pend_q   <= RES_READY;
            nw_q     <= 1'b0;
            dev_q    <= '0;
            baddr_q  <= '0;
            sym_go   <= 1'b0;
            done     <= 1'b0;
            result   <= RES_READY;
            attempts <= '0;
        end else begin
            sym_go <= 1'b0;
            done   <= 1'b0;
            if (st == C_IDLE) begin
                if (cmd_valid) begin
                    nw_q     <= cmd_next_write;
                    dev_q    <= cmd_dev;
                    baddr_q  <= cmd_baddr;
                    attempts <= '0;
                    issued   <= 1'b0;
                    st       <= C_START;
                end
            end else if (sym_done) begin
                issued <= 1'b0;
                case (st)
                    C_START: begin
                        attempts <= attempts + 1'b1;
                        sh       <= SH_W'({dev_q, 1'b0}) << (SH_W - FR_W);
                        idx      <= '0;
                        st       <= C_ADDR;
                    end
                    C_ADDR: begin
                        sh <= sh << 1;
                        if (idx == IDX_W'(FR_W - 1)) begin
                            st <= C_ACK;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    C_ACK: begin
                        if (!rx_bit && nw_q) begin
                            sh  <= SH_W'(baddr_q) << (SH_W - BA_W);
                            idx <= '0;
                            st  <= C_BADDR;
                        end else begin
                            st <= C_STOP;
                            if (!rx_bit) begin
                                retry_q <= 1'b0;
                                pend_q  <= RES_READY;
                            end else if (attempts == CNT_W'(MAX_TRIES)) begin
                                retry_q <= 1'b0;
                                pend_q  <= RES_TIMEOUT;
                            end else begin
                                retry_q <= 1'b1;
                            end
                        end
                    end
                    C_STOP: begin
                        if (retry_q) begin
                            st <= C_START;
                        end else begin
                            st     <= C_IDLE;
                            done   <= 1'b1;
                            result <= pend_q;
                        end
                    end
                    C_BADDR: begin
                        sh <= sh << 1;
                        if (idx == IDX_W'(BA_W - 1)) begin
                            st <= C_BACK;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    default: begin
                        st     <= C_IDLE;
                        done   <= 1'b1;
                        result <= RES_WRCONT;
                    end
                endcase
            end else if (!issued) begin
                sym_go <= 1'b1;
                issued <= 1'b1;
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ATTEMPTS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        attempts <= CNT_W'(MAX_TRIES)); // R3
    AST_TIMEOUT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_TIMEOUT) |-> (attempts == CNT_W'(MAX_TRIES))); // R6
endmodule

// File: rtl/ackpoll_seq.sv
// Acknowledge-polling master sequencer, top level.
// Joins the quarter-tick divider, the bit engine and the byte sequencer.
// SCL is driven push-pull. SDA is open-drain: sda_oe=1 pulls it low.
// Assumes sda_i is the resolved wire level, synchronous to clk.
module ackpoll_seq
    import ackpoll_pkg::*;
#(
    parameter int QDIV      = 4,
    parameter int MAX_TRIES = 8,
    parameter int DEV_W     = 7,
    parameter int BA_W      = 8,
    localparam int CNT_W    = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_next_write,
    input  logic [DEV_W-1:0] cmd_dev_addr,
    input  logic [BA_W-1:0]  cmd_byte_addr,
    output logic             cmd_ready,
    output logic             done,
    output logic [1:0]       result,
    output logic [CNT_W-1:0] attempts,
    output logic             scl_o,
    output logic             sda_oe,
    input  logic             sda_i
);
    logic tick;
    logic phy_active;
    logic sym_go;
    logic sym_done;
    logic sym_bit;
    logic rx_bit;
    logic in_ack;
    sym_e sym_kind;

    ackpoll_tick #(.QDIV(QDIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (phy_active),
        .tick  (tick)
    );

    ackpoll_phy u_phy (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .go     (sym_go),
        .kind   (sym_kind),
        .tx_bit (sym_bit),
        .sda_i  (sda_i),
        .active (phy_active),
        .done   (sym_done),
        .rx_bit (rx_bit),
        .scl_o  (scl_o),
        .sda_oe (sda_oe)
    );

    ackpoll_ctrl #(
        .DEV_W     (DEV_W),
        .BA_W      (BA_W),
        .MAX_TRIES (MAX_TRIES),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_next_write (cmd_next_write),
        .cmd_dev        (cmd_dev_addr),
        .cmd_baddr      (cmd_byte_addr),
        .cmd_ready      (cmd_ready),
        .sym_go         (sym_go),
        .sym_kind       (sym_kind),
        .sym_bit        (sym_bit),
        .sym_done       (sym_done),
        .rx_bit         (rx_bit),
        .in_ack         (in_ack),
        .done           (done),
        .result         (result),
        .attempts       (attempts)
    );

    AST_ACK_SLOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && phy_active) |-> !sda_oe); // R7
    AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_READY) |-> (scl_o && !sda_oe)); // R4
    AST_WRCONT_SCL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_WRCONT) |-> !scl_o); // R5
endmodule

// File: tb/ackpoll_seq_tb.sv
module ackpoll_seq_tb;
    localparam int QDIV = 4;
    localparam int M    = 8;
    localparam int CW   = $clog2(M + 1);
    localparam logic [6:0] SLV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_next_write = 1'b0;
    logic [6:0] cmd_dev_addr = '0;
    logic [7:0] cmd_byte_addr = '0;
    logic cmd_ready, done, scl_o, sda_oe;
    logic [1:0] result;
    logic [CW-1:0] attempts;
    logic slv_oe = 1'b0;
    wire  sda_bus = !(sda_oe || slv_oe);

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    ackpoll_seq #(.QDIV(QDIV), .MAX_TRIES(M), .DEV_W(7), .BA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_next_write(cmd_next_write), .cmd_dev_addr(cmd_dev_addr),
        .cmd_byte_addr(cmd_byte_addr), .cmd_ready(cmd_ready), .done(done),
        .result(result), .attempts(attempts), .scl_o(scl_o),
        .sda_oe(sda_oe), .sda_i(sda_bus)
    );

    // Slave model: an EEPROM that stays busy for busy_left probes.
    int busy_left = 0;
    int att_seen = 0;
    int stops_seen = 0;
    int bitcnt = 0;
    int phase = 0;          // 0 none, 1 address frame, 2 byte address
    logic ack_slot = 1'b0;
    logic acked = 1'b0;
    logic [7:0] shreg = '0;
    logic [7:0] addr_seen = '0;
    logic [7:0] ba_seen = '0;
    logic p_scl = 1'b1;
    logic p_sda = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_scl && scl_o && p_sda && !sda_bus) begin
                phase = 1; bitcnt = 0; ack_slot = 1'b0; slv_oe = 1'b0;
            end else if (p_scl && scl_o && !p_sda && sda_bus) begin
                stops_seen++; phase = 0; slv_oe = 1'b0;
            end else if (!p_scl && scl_o) begin
                if (phase != 0 && bitcnt < 8) begin
                    shreg = {shreg[6:0], sda_bus}; bitcnt++;
                end
            end else if (p_scl && !scl_o && phase != 0) begin
                if (ack_slot) begin
                    slv_oe = 1'b0; ack_slot = 1'b0; bitcnt = 0;
                    phase = (phase == 1 && acked) ? 2 : 0;
                end else if (bitcnt == 8) begin
                    ack_slot = 1'b1;
                    if (phase == 1) begin
                        att_seen++; addr_seen = shreg;
                        if (shreg[7:1] == SLV && busy_left == 0) acked = 1'b1;
                        else begin
                            acked = 1'b0;
                            if (shreg[7:1] == SLV) busy_left--;
                        end
                        slv_oe = acked;
                    end else begin
                        ba_seen = shreg; slv_oe = 1'b1;
                    end
                end
            end
        end
        p_scl = scl_o;
        p_sda = sda_bus;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_att(input int busy, input bit match);
        return (match && busy < M) ? busy + 1 : M;
    endfunction

    function automatic int exp_res(input int busy, input bit match, input bit nw);
        if (!match || busy >= M) return 2;
        return nw ? 1 : 0;
    endfunction

    function automatic int exp_stops(input int busy, input bit match, input bit nw);
        if (!match || busy >= M) return M;
        return nw ? busy : busy + 1;
    endfunction

    task automatic run_cmd(input bit nw, input logic [6:0] dev,
                           input logic [7:0] ba, input int busy, input bit spam);
        int waited;
        int dones;
        bit match;
        int er;
        match = (dev == SLV);
        busy_left = busy; att_seen = 0; stops_seen = 0;
        @(negedge clk);
        cmd_next_write = nw; cmd_dev_addr = dev; cmd_byte_addr = ba;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        waited = 0; dones = 0;
        while (done !== 1'b1 && waited < 30000) begin
            @(negedge clk);
            waited++;
            if (spam && waited == 60) begin
                cmd_dev_addr = dev ^ 7'h01; cmd_next_write = !nw; cmd_valid = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
        end
        cmd_valid = 1'b0;
        if (waited >= 30000) begin
            chk("R8 watchdog: done never came", 0, 1);
            return;
        end
        dones = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        er = exp_res(busy, match, nw);
        chk("R8 done pulses", dones, 1);
        chk((er == 2) ? "R6 result" : (nw ? "R5 result" : "R4 result"), result, er);
        chk("R3 attempts port", attempts, exp_att(busy, match));
        chk("R3 probes on bus", att_seen, exp_att(busy, match));
        chk("R3 stops on bus", stops_seen, exp_stops(busy, match, nw));
        chk("R2 address frame", addr_seen, {dev, 1'b0});
        chk("R8 ready after done", cmd_ready, 1);
        if (er == 1) begin
            chk("R5 byte address", ba_seen, ba);
            chk("R5 scl held low", scl_o, 0);
        end else begin
            chk("R4 scl idle high", scl_o, 1);
            chk("R4 sda released", sda_oe, 0);
        end
    endtask

    // Global watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL R8 global watchdog: actual %0d expected %0d", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scl after reset", scl_o, 1);
        chk("R1 sda after reset", sda_oe, 0);
        chk("R1 ready after reset", cmd_ready, 1);
        chk("R1 done after reset", done, 0);

        run_cmd(1'b0, SLV, 8'h3C, 0, 1'b0);      // R4 immediate ack
        run_cmd(1'b1, SLV, 8'hA5, 0, 1'b0);      // R5 immediate ack
        run_cmd(1'b0, SLV, 8'h00, 3, 1'b0);      // R3 retries then ready
        run_cmd(1'b1, SLV, 8'h81, M - 1, 1'b0);  // R5 ack on the last allowed probe
        run_cmd(1'b0, SLV, 8'h11, M, 1'b0);      // R6 timeout exactly at limit
        run_cmd(1'b1, SLV, 8'h22, M + 2, 1'b0);  // R6 timeout, write requested
        run_cmd(1'b1, 7'h2B, 8'h5A, 0, 1'b0);    // R6 wrong device never acks
        run_cmd(1'b0, SLV, 8'h77, 2, 1'b1);      // R8 stray command ignored
        run_cmd(1'b1, SLV, 8'hC3, 1, 1'b1);      // R8 stray command ignored

        for (int k = 0; k < 10; k++) begin
            bit nw;
            logic [6:0] dev;
            nw  = 1'($urandom % 2);
            dev = (($urandom % 6) == 0) ? 7'($urandom) : SLV;
            run_cmd(nw, dev, 8'($urandom), int'($urandom % (M + 3)), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule